// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer Core

This block holds several independent timer channels, each driving one pulse-width-modulated output. Every channel runs a down counter that advances only on its own tick strobe, so the time base is chosen outside the block. Software writes a period value and a compare value into two buffer registers per channel. Those values reach the running counter only through an explicit manual-update step or at the automatic reload at the end of each period. This lets a new waveform be staged without glitching the one in flight.

A single shared control word holds a four-bit field per channel: start, manual update, output invert and auto-reload. The field layout is irregular. Channel 0 sits in the lowest nibble. The next nibble is left empty. Channel k (k at least 1) sits in nibble k+1. The last channel has no inverter, and its auto-reload flag sits one bit lower than on the other channels. The usual bring-up is two writes: first set manual update with start clear, then clear manual update while setting start and auto-reload. A channel also emits a one-cycle period-end pulse each time its count wraps.

Top module: `pwm_timer_core`

## Requirements
- R1: After a synchronous active-low reset, the control word, all buffers and all counters are zero, `period_end` is low and every `pwm_out` bit is high.
- R2: Register map: address 0 is the control word, address 1+2c is the period buffer of channel c, and address 2+2c is the compare buffer of channel c. Channel c uses nibble n = 0 when c = 0 and n = c+1 otherwise. In that nibble, bit 4n is start, bit 4n+1 is manual update, bit 4n+2 is invert and bit 4n+3 is auto-reload. For the last channel, bit 4n+2 is auto-reload and bit 4n+3 does not exist. Unused control bits read back 0; with the default five channels, writing all ones reads back 0x7FFF0F.
- R3: While a channel's manual-update bit is set, its counter and active compare are loaded from the buffers on every clock, and ticks are ignored.
- R4: With start set and manual update clear, each tick decrements a nonzero counter. A tick at zero ends the period, so a period buffer of L gives L+1 ticks per period. With start clear, ticks have no effect.
- R5: A tick at zero with auto-reload set reloads the counter and compare from the buffers. With auto-reload clear, the counter stays at zero and the channel halts: it produces no further decrements or period-end pulses until the next manual update.
- R6: A channel is active while its counter is greater than its active compare, or whenever the compare is all ones. A compare of L−d, for a period buffer L and 1 ≤ d ≤ L, gives exactly d active ticks per period.
- R7: With invert set, `pwm_out` equals the active state. With invert clear, it is the complement. The last channel has no inverter and always drives the complement.
- R8: `period_end[c]` is high for one cycle, in the cycle right after the tick that ends a period.
- R9: Writing a buffer while the channel runs does not change the current period; the new values take effect at the next reload.
- R10: Buffer reads return the stored value, which is the low counter-width bits of the written data. Reads of unmapped addresses return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| tick | input | NUM_CH | Per-channel count strobe |
| pwm_out | output | NUM_CH | Per-channel waveform output |
| period_end | output | NUM_CH | Per-channel one-cycle period-wrap pulse |

## Verification
The vector table sweeps period and compare pairs across several channels. It covers a middle duty, the minimum single-tick duty, a compare equal to the period (no active ticks), a compare of zero, and the all-ones compare that forces full duty. Each pattern is run with invert set and with invert clear, and once on the last channel, so a wrong inverter hookup or a wrong auto-reload bit position shows up as a wrong count of high samples. Directed runs separate buffer writes made mid-period from writes made at a reload, separate a halt from a reload when auto-reload is cleared, and separate a held counter from a running one when start is clear.

// File: rtl/pwm_timer_pkg.sv
// Package: shared constants and helpers for the PWM timer core.
// Assumes at most 15 channels so the control mask fits in 64 bits.
package pwm_timer_pkg;

    localparam int OFS_START  = 0;
    localparam int OFS_MANUAL = 1;
    localparam int OFS_INVERT = 2;
    localparam int OFS_RELOAD = 3;
    localparam int OFS_RELOAD_LAST = 2;

    // Nibble index of a channel inside the shared control word (gap after channel 0).
    function automatic int nib_idx(input int ch);
        return (ch == 0) ? 0 : ch + 1;
    endfunction

    // Mask of implemented control bits for n channels.
    function automatic logic [63:0] ctrl_mask(input int n);
        logic [63:0] m;
        m = '0;
        for (int c = 0; c < n; c++) begin
            if (c == n - 1) m[4*nib_idx(c) +: 3] = 3'b111;
            else            m[4*nib_idx(c) +: 4] = 4'b1111;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
// Module: register file for the control word and the per-channel period and
// compare buffers, plus the combinational read mux and control field decode.
// Assumes CNT_W <= DATA_W and 4*(NUM_CH+1) <= DATA_W.
module pwm_regfile #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_CH-1:0]             f_start,
    output logic [NUM_CH-1:0]             f_manual,
    output logic [NUM_CH-1:0]             f_invert,
    output logic [NUM_CH-1:0]             f_reload,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf
);
    import pwm_timer_pkg::*;

    localparam int CTRL_W = 4 * (NUM_CH + 1);
    localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'(ctrl_mask(NUM_CH));
    localparam int USED_W = (CTRL_W > CNT_W) ? CTRL_W : CNT_W;

    logic [CTRL_W-1:0] ctrl_q;

    // Control word: only implemented bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == '0)
            ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_MASK;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
            localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(1 + 2*c);
            localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(2 + 2*c);
            localparam int B = 4 * nib_idx(c);
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W-1:0] cmp_q;

            // Period buffer of this channel.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (wr_en && wr_addr == A_CNT)
                    cnt_q <= wr_data[CNT_W-1:0];
            end

            // Compare buffer of this channel.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cmp_q <= '0;
                else if (wr_en && wr_addr == A_CMP)
                    cmp_q <= wr_data[CNT_W-1:0];
            end

            assign cnt_buf[c]  = cnt_q;
            assign cmp_buf[c]  = cmp_q;
            assign f_start[c]  = ctrl_q[B + OFS_START];
            assign f_manual[c] = ctrl_q[B + OFS_MANUAL];

            if (c == NUM_CH - 1) begin : g_last
                assign f_invert[c] = 1'b0;
                assign f_reload[c] = ctrl_q[B + OFS_RELOAD_LAST];
            end else begin : g_norm
                assign f_invert[c] = ctrl_q[B + OFS_INVERT];
                assign f_reload[c] = ctrl_q[B + OFS_RELOAD];
            end
        end

        if (DATA_W > USED_W) begin : g_spare
            logic unused_wr_hi;
            assign unused_wr_hi = ^wr_data[DATA_W-1:USED_W];
        end
    endgenerate

    // Read mux: control word, buffers, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0)
            rd_data = DATA_W'(ctrl_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(1 + 2*c)) rd_data = DATA_W'(cnt_buf[c]);
            if (rd_addr == ADDR_W'(2 + 2*c)) rd_data = DATA_W'(cmp_buf[c]);
        end
    end

endmodule

// File: rtl/pwm_outstage.sv
// Module: output stage; forms the active state from counter and compare and
// applies the optional inverter. HAS_INV=0 builds a channel without inverter.
module pwm_outstage #(
    parameter int CNT_W   = 16,
    parameter bit HAS_INV = 1'b1
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             invert,
    output logic             pin
);
    logic active;

    // Active above the compare, or always when the compare is all ones.
    assign active = (cnt > cmp) || (&cmp);

    generate
        if (HAS_INV) begin : g_inv
            assign pin = invert ? active : ~active;
        end else begin : g_noinv
            logic unused_invert;
            assign unused_invert = invert;
            assign pin = ~active;
        end
    endgenerate

endmodule

// File: rtl/pwm_chan.sv
// Module: one timer channel; down counter with manual load, auto-reload or
// halt at period end, registered period-end pulse. Assumes tick is a
// single-clock strobe in the clk domain.
module pwm_chan #(
    parameter int CNT_W   = 16,
    parameter bit HAS_INV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             manual,
    input  logic             invert,
    input  logic             reload,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pin,
    output logic             period_end,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             halted_q;
    logic             pe_q;
    logic             step;

    assign step = start && tick && !halted_q;

    // Counter, active compare, halt flag and period-end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmp_q    <= '0;
            halted_q <= 1'b0;
            pe_q     <= 1'b0;
        end else begin
            pe_q <= 1'b0;
            if (manual) begin
                cnt_q    <= cnt_buf;
                cmp_q    <= cmp_buf;
                halted_q <= 1'b0;
            end else if (step) begin
                if (cnt_q == '0) begin
                    pe_q <= 1'b1;
                    if (reload) begin
                        cnt_q <= cnt_buf;
                        cmp_q <= cmp_buf;
                    end else begin
                        halted_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    pwm_outstage #(.CNT_W(CNT_W), .HAS_INV(HAS_INV)) u_out (
        .cnt    (cnt_q),
        .cmp    (cmp_q),
        .invert (invert),
        .pin    (pin)
    );

    assign period_end = pe_q;
    assign cnt_o      = cnt_q;
    assign cmp_o      = cmp_q;

endmodule

// File: rtl/pwm_timer_core.sv
// Module: top of the multi-channel PWM timer; register file plus one channel
// per output. The last channel is built without output inverter.
module pwm_timer_core #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(2*NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] period_end
);
    logic [NUM_CH-1:0]            ch_start;
    logic [NUM_CH-1:0]            ch_manual;
    logic [NUM_CH-1:0]            ch_invert;
    logic [NUM_CH-1:0]            ch_reload;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp;

    pwm_regfile #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .f_start  (ch_start),
        .f_manual (ch_manual),
        .f_invert (ch_invert),
        .f_reload (ch_reload),
        .cnt_buf  (cnt_buf),
        .cmp_buf  (cmp_buf)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pwm_chan #(
                .CNT_W(CNT_W), .HAS_INV(c != NUM_CH - 1)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick[c]),
                .start      (ch_start[c]),
                .manual     (ch_manual[c]),
                .invert     (ch_invert[c]),
                .reload     (ch_reload[c]),
                .cnt_buf    (cnt_buf[c]),
                .cmp_buf    (cmp_buf[c]),
                .pin        (pwm_out[c]),
                .period_end (period_end[c]),
                .cnt_o      (ch_cnt[c]),
                .cmp_o      (ch_cmp[c])
            );
        end
    endgenerate

endmodule

// File: rtl/pwm_timer_core_chk.sv
// Module: assertion checker for pwm_timer_core, attached by bind below.
// Observes control fields, buffers and per-channel counter state.
module pwm_timer_core_chk #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            tick,
    input logic [NUM_CH-1:0]            period_end,
    input logic [NUM_CH-1:0]            ch_start,
    input logic [NUM_CH-1:0]            ch_manual,
    input logic [NUM_CH-1:0]            ch_reload,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp
);
    // R1: first cycle out of reset is quiet with cleared counters.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (period_end == '0 && ch_cnt == '0));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_a
            // R3: manual update copies the period buffer.
            a_r3_manual_copy: assert property (@(posedge clk) disable iff (!rst_n)
                ch_manual[c] |=> ch_cnt[c] == $past(cnt_buf[c]));
            // R4: no tick or no start means the counter holds.
            a_r4_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_manual[c] && (!tick[c] || !ch_start[c])) |=> $stable(ch_cnt[c]));
            // R5: a period end without auto-reload leaves the counter at zero.
            a_r5_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_manual[c] && ch_start[c] && tick[c] && ch_cnt[c] == '0 && !ch_reload[c])
                |=> ch_cnt[c] == '0);
            // R8: a period-end pulse always follows a tick.
            a_r8_pe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
                period_end[c] |-> $past(tick[c]));
            // R9: the active compare changes only at a load point.
            a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_manual[c] && !(tick[c] && ch_cnt[c] == '0)) |=> $stable(ch_cmp[c]));
        end
    endgenerate

endmodule

bind pwm_timer_core pwm_timer_core_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .period_end (period_end),
    .ch_start   (ch_start),
    .ch_manual  (ch_manual),
    .ch_reload  (ch_reload),
    .cnt_buf    (cnt_buf),
    .ch_cnt     (ch_cnt),
    .ch_cmp     (ch_cmp)
);

// File: tb/pwm_timer_core_tb_top.sv
module pwm_timer_core_tb_top;
    localparam int NUM_CH = 5;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int LAST   = NUM_CH - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_CH-1:0] tick = '0;
    logic [NUM_CH-1:0] pwm_out;
    logic [NUM_CH-1:0] period_end;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pwm_timer_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .pwm_out(pwm_out),
        .period_end(period_end)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [15:0] per;
        logic [15:0] cmp;
        logic        inv;
        logic [7:0]  hi;
    } vec_t;

    // Stimulus: channel, period buffer, compare, invert, expected high samples per period.
    localparam vec_t VEC [8] = '{
        '{3'd1, 16'd4, 16'd2,      1'b1, 8'd2},
        '{3'd1, 16'd4, 16'd2,      1'b0, 8'd3},
        '{3'd0, 16'd9, 16'd0,      1'b1, 8'd9},
        '{3'd2, 16'd9, 16'hFFFF,   1'b1, 8'd10},
        '{3'd3, 16'd7, 16'd6,      1'b1, 8'd1},
        '{3'd0, 16'd7, 16'd7,      1'b1, 8'd0},
        '{3'd2, 16'd1, 16'd0,      1'b1, 8'd1},
        '{3'd4, 16'd4, 16'd2,      1'b1, 8'd3}
    };

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Control word per R2 layout.
    function automatic logic [31:0] ctl_word(input int ch, input logic st, input logic man,
                                             input logic inv, input logic ar);
        logic [31:0] w;
        int b;
        w = '0;
        b = 4 * ((ch == 0) ? 0 : ch + 1);
        w[b]     = st;
        w[b + 1] = man;
        if (ch == LAST) begin
            w[b + 2] = ar;
        end else begin
            w[b + 2] = inv;
            w[b + 3] = ar;
        end
        return w;
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic tick_once(input int ch, output logic lvl, output logic pe);
        @(negedge clk);
        lvl = pwm_out[ch];
        tick = '0; tick[ch] = 1'b1;
        @(negedge clk);
        tick = '0;
        pe = period_end[ch];
    endtask

    // Run n ticks; count high samples; pe_ok when the pulse follows only the last tick.
    task automatic measure(input int ch, input int n, output int hi, output logic pe_ok);
        logic l, p;
        hi = 0; pe_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick_once(ch, l, p);
            if (l) hi++;
            if (p !== (i == n - 1)) pe_ok = 1'b0;
        end
    endtask

    task automatic arm(input int ch, input logic [15:0] per, input logic [15:0] cmp,
                       input logic inv, input logic ar);
        wr(ADDR_W'(1 + 2*ch), {16'd0, per});
        wr(ADDR_W'(2 + 2*ch), {16'd0, cmp});
        wr('0, ctl_word(ch, 1'b0, 1'b1, inv, 1'b0));
        wr('0, ctl_word(ch, 1'b1, 1'b0, inv, ar));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int hi;
        logic ok, l, p;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        @(negedge clk);
        check(32'(pwm_out), 32'h1F, "R1", "pwm_out after reset");
        check(32'(period_end), 32'h0, "R1", "period_end after reset");
        rd(4'd0, d);  check(d, 32'h0, "R1", "control after reset");
        rd(4'd7, d);  check(d, 32'h0, "R1", "period buffer ch3 after reset");

        // R2: implemented control bits.
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d);  check(d, 32'h007F_FF0F, "R2", "control readback mask");
        wr(4'd0, 32'h0);

        // R10: buffer storage and unmapped addresses.
        wr(4'd5, 32'h0000_1234);
        rd(4'd5, d);  check(d, 32'h1234, "R10", "period buffer ch2 readback");
        wr(4'd8, 32'hABCD_5678);
        rd(4'd8, d);  check(d, 32'h5678, "R10", "compare buffer ch3 truncated");
        wr(4'd13, 32'hFFFF_FFFF);
        rd(4'd13, d); check(d, 32'h0, "R10", "unmapped read");
        rd(4'd8, d);  check(d, 32'h5678, "R10", "buffer after unmapped write");

        // R6 R7 R8 R4: table of period/compare/invert patterns.
        for (int v = 0; v < 8; v++) begin
            arm(int'(VEC[v].ch), VEC[v].per, VEC[v].cmp, VEC[v].inv, 1'b1);
            measure(int'(VEC[v].ch), int'(VEC[v].per) + 1, hi, ok);
            check(32'(hi), 32'(VEC[v].hi), "R6/R7", $sformatf("high samples row %0d", v));
            check(32'(ok), 32'h1, "R8", $sformatf("period_end placement row %0d", v));
            wr(4'd0, 32'h0);
        end

        // R9: buffer writes mid-period take effect at the reload.
        arm(2, 16'd9, 16'd4, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) tick_once(2, l, p);
        wr(4'd5, 32'd3);
        wr(4'd6, 32'd0);
        measure(2, 7, hi, ok);
        check(32'(hi), 32'd2, "R9", "rest of old period high samples");
        check(32'(ok), 32'h1, "R9", "old period length");
        measure(2, 4, hi, ok);
        check(32'(hi), 32'd3, "R9", "new period high samples");
        check(32'(ok), 32'h1, "R9", "new period length");
        wr(4'd0, 32'h0);

        // R5: clearing auto-reload finishes the period then halts.
        arm(3, 16'd3, 16'd1, 1'b1, 1'b1);
        tick_once(3, l, p);
        check(32'(l), 32'h1, "R5", "level at period start");
        wr(4'd0, ctl_word(3, 1'b1, 1'b0, 1'b1, 1'b0));
        tick_once(3, l, p);
        tick_once(3, l, p);
        tick_once(3, l, p);
        check(32'(p), 32'h1, "R5", "period_end at final tick");
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick_once(3, l, p);
            if (l !== 1'b0 || p !== 1'b0) ok = 1'b0;
        end
        check(32'(ok), 32'h1, "R5", "halted: low and no period_end");
        wr(4'd0, 32'h0);

        // R4: start clear, ticks ignored; R3: manual update loads buffers.
        wr(4'd3, 32'd4);
        wr(4'd4, 32'd2);
        wr(4'd0, ctl_word(1, 1'b0, 1'b1, 1'b1, 1'b0));
        wr(4'd0, ctl_word(1, 1'b0, 1'b0, 1'b1, 1'b0));
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick_once(1, l, p);
            if (l !== 1'b1 || p !== 1'b0) ok = 1'b0;
        end
        check(32'(ok), 32'h1, "R4", "start clear holds counter");
        wr(4'd0, ctl_word(1, 1'b1, 1'b0, 1'b1, 1'b0));
        measure(1, 5, hi, ok);
        check(32'(hi), 32'd2, "R3", "manual-loaded period high samples");
        check(32'(ok), 32'h1, "R4", "period of L+1 ticks after start");

        finish_run();
    end

endmodule